// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block collects interrupt requests from up to four sources in each of 31 groups and presents the processor with one priority level. Group 0 is non-maskable: a source event that leaves it pending produces a single-cycle pulse on a dedicated output. Group 1 is reserved and has no storage. Groups 2 to 30 are maskable. Each has a 4-bit request field, a 4-bit enable mask and a 3-bit level, and a lower level number means higher priority. Edge or level detection happens upstream. Each source arrives as a one-cycle set pulse.

Software reaches the block through a byte-wide register port. Every group has a two-byte control window at byte offset `group*4`. A status byte sits at offset 0x80 and names the group that the processor last acknowledged. The port has no back-pressure. An access strobe is accepted in the cycle it is presented. A read returns its byte in the following cycle, and `bus_rdata` is zero in every other cycle.

The processor acknowledges a maskable interrupt by pulsing `ack` together with the level it is taking. The block then latches the group that is currently winning. An acknowledge whose level differs from the driven level is recorded in a sticky error flag.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset every request, enable and level field is 0 and the accepted-group register is 0. `irq_level` is 7, `nmi_pulse` and `ack_err` are 0, and every register reads 0.
- R2: Set pulse `src_set[g*4+s]` sets request bit s of group g at the next clock edge. Pulses aimed at group 1 have no effect.
- R3: A group is pending when (request AND enable) is nonzero. When no maskable group (2 to 30) is pending, `irq_level` is 7.
- R4: `irq_level` is the lowest level among the pending maskable groups. A group whose level is 7 never wins. On equal levels, the lowest-numbered group is selected.
- R5: For a maskable group, byte 0 reads {request[3:0], request AND enable[3:0]}. Byte 1 reads {0, level[2:0], enable[3:0]}, and a write to byte 1 loads level from bits 6:4 and enable from bits 3:0.
- R6: A write to byte 0 of a maskable group acts on each bit s independently. Bit s+4 = 1 with bit s = 1 sets request bit s, bit s+4 = 0 with bit s = 1 clears it, and bit s = 0 leaves it unchanged. A set pulse in the same cycle as a clear wins.
- R7: For group 0, byte 0 reads the request in bits 3:0 with bits 7:4 zero, and writing 1 to bit s clears request bit s. Byte 1 holds only the enable in bits 3:0, and its level bits are ignored and read as 0.
- R8: `nmi_pulse` is high for exactly the one cycle after a group 0 set pulse whose edge leaves group 0 pending. Register writes never produce it.
- R9: When `ack` is high, the group selected in that cycle is latched. Offset 0x80 then reads group*4 while that group stays pending and 0 once it is not. Offset 0x81 reads 0.
- R10: An `ack` whose `ack_level` differs from `irq_level` in that cycle sets `ack_err`, which stays at 1 until reset.
- R11: Read data appears on `bus_rdata` exactly one cycle after the read strobe. Writes to group 1, to offsets 2 and 3, to offsets from 0x7C up and to the status bytes are ignored. Reads of unmapped offsets return 0.
- R12: `irq_level` reflects a register write or a set pulse in the cycle right after the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | 124 | Per-source set pulses, bit g*4+s for source s of group g |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read strobe, else 0 |
| ack | input | 1 | Processor acknowledge pulse |
| ack_level | input | 3 | Level the processor is acknowledging |
| irq_level | output | 3 | Level of the winning maskable group, 7 when none |
| nmi_pulse | output | 1 | One-cycle non-maskable request |
| ack_err | output | 1 | Sticky acknowledge-level mismatch flag |

## Verification
Four kinds of check run on every cycle. They cover that a set pulse or a write sets or clears the request bits it names, that group 0 bits clear on a write, that an idle controller drives level 7 and that a non-7 level always points at a pending group. They also cover that the non-maskable pulse only appears with group 0 pending, and that the error flag never drops. Some behaviour only shows up in the bench scenarios. That includes the tie between equal-level groups, the hiding of level-7 groups and the set-beats-clear collision. It also includes the accepted-group readback going to zero after its request is cleared, and the read latency. The bench further confirms that writes to reserved or unmapped offsets change nothing readable.

// File: rtl/gic_pkg.sv
package gic_pkg;

  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    GK_NMI  = 2'd0,
    GK_RSVD = 2'd1,
    GK_MASK = 2'd2
  } grp_kind_e;

  // Role of group g given the first maskable group number.
  function automatic grp_kind_e kind_of(input int unsigned g, input int unsigned first_mask);
    if (g == 0) return GK_NMI;
    else if (g < first_mask) return GK_RSVD;
    return GK_MASK;
  endfunction

endpackage

// File: rtl/gic_group.sv
module gic_group
  import gic_pkg::*;
#(
  parameter int unsigned NSRC  = 4,
  parameter int unsigned LVL_W = 3,
  parameter grp_kind_e   KIND  = GK_MASK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_set,
  input  logic              wr_ctl,
  input  logic              wr_cfg,
  input  logic [DATA_W-1:0] wdata,
  output logic [NSRC-1:0]   req,
  output logic [NSRC-1:0]   en,
  output logic [LVL_W-1:0]  lvl,
  output logic              pend,
  output logic              nmi_hit
);

  localparam int unsigned HI_LSB = DATA_W / 2;

  logic [NSRC-1:0] wd_id;
  logic [NSRC-1:0] wd_ir;
  logic [NSRC-1:0] req_wr;
  logic [NSRC-1:0] req_nxt;
  logic [NSRC-1:0] en_nxt;
  logic            unused_wdata;

  assign wd_id        = wdata[0 +: NSRC];
  assign wd_ir        = wdata[HI_LSB +: NSRC];
  assign unused_wdata = ^wdata;
  assign en_nxt       = wr_cfg ? wd_id : en;
  assign req_nxt      = req_wr | src_set;
  assign pend         = |(req & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= '0;
      en  <= '0;
    end else begin
      req <= req_nxt;
      en  <= en_nxt;
    end
  end

  // R2: a set pulse always lands in the request field
  a_r2_src_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_set) |=> ((req & $past(src_set)) == $past(src_set)));

  if (KIND == GK_NMI) begin : g_nmi
    // Writes to byte 0 clear the bits marked with 1.
    always_comb begin
      req_wr = req;
      if (wr_ctl) req_wr = req & ~wd_id;
    end
    assign lvl     = '1;
    assign nmi_hit = (|src_set) && (|(req_nxt & en_nxt));

    // R7: a written 1 clears, unless a pulse re-sets it
    a_r7_nmi_clear: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl |=> ((req & $past(wd_id & ~src_set)) == '0));
  end else begin : g_mask
    logic [LVL_W-1:0] lvl_q;

    // Per-bit set/clear: ID selects the bit, IR gives its new value.
    always_comb begin
      req_wr = req;
      if (wr_ctl) req_wr = (wd_id & wd_ir) | (~wd_id & req);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lvl_q <= '0;
      else if (wr_cfg) lvl_q <= wdata[HI_LSB +: LVL_W];
    end

    assign lvl     = lvl_q;
    assign nmi_hit = 1'b0;

    // R6: selected bits with IR=1 end up set
    a_r6_set_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl |=> ((req & $past(wd_id & wd_ir)) == $past(wd_id & wd_ir)));
    // R6: selected bits with IR=0 end up clear unless a pulse wins
    a_r6_clear_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl |=> ((req & $past(wd_id & ~wd_ir & ~src_set)) == '0));
  end

endmodule

// File: rtl/gic_prio_scan.sv
module gic_prio_scan #(
  parameter int unsigned NGRP       = 31,
  parameter int unsigned FIRST_MASK = 2,
  parameter int unsigned LVL_W      = 3,
  localparam int unsigned GRP_W     = $clog2(NGRP)
) (
  input  logic [NGRP-1:0]       pend,
  input  logic [NGRP*LVL_W-1:0] lvl_flat,
  output logic [LVL_W-1:0]      best_lvl,
  output logic [GRP_W-1:0]      best_grp
);

  logic unused_low;
  assign unused_low = ^{pend[FIRST_MASK-1:0], lvl_flat[FIRST_MASK*LVL_W-1:0]};

  // Ascending scan; strict compare keeps the lowest group on a tie.
  always_comb begin
    best_lvl = '1;
    best_grp = '0;
    for (int g = FIRST_MASK; g < NGRP; g++) begin
      if (pend[g] && (lvl_flat[g*LVL_W +: LVL_W] < best_lvl)) begin
        best_lvl = lvl_flat[g*LVL_W +: LVL_W];
        best_grp = GRP_W'(g);
      end
    end
  end

endmodule

// File: rtl/gic_regbus.sv
module gic_regbus
  import gic_pkg::*;
#(
  parameter int unsigned NGRP       = 31,
  parameter int unsigned NSRC       = 4,
  parameter int unsigned LVL_W      = 3,
  parameter int unsigned FIRST_MASK = 2,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned STAT_BASE  = 128,
  localparam int unsigned GRP_W     = $clog2(NGRP)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [NGRP*NSRC-1:0]  req_flat,
  input  logic [NGRP*NSRC-1:0]  en_flat,
  input  logic [NGRP*LVL_W-1:0] lvl_flat,
  input  logic [GRP_W-1:0]      acc_grp,
  input  logic                  acc_pend,
  output logic [NGRP-1:0]       wr_ctl,
  output logic [NGRP-1:0]       wr_cfg,
  output logic [DATA_W-1:0]     bus_rdata
);

  localparam int unsigned HI_LSB  = DATA_W / 2;
  localparam int unsigned ICR_END = NGRP * 4;

  logic              icr_hit;
  logic [GRP_W-1:0]  grp_idx;
  logic [1:0]        off;
  logic [DATA_W-1:0] rd_val;

  assign icr_hit = (bus_addr < ADDR_W'(ICR_END));
  assign grp_idx = bus_addr[2 +: GRP_W];
  assign off     = bus_addr[1:0];

  for (genvar g = 0; g < NGRP; g++) begin : g_dec
    localparam grp_kind_e K = kind_of(g, FIRST_MASK);
    logic hit;
    assign hit       = bus_en && bus_we && icr_hit && (grp_idx == GRP_W'(g)) && (K != GK_RSVD);
    assign wr_ctl[g] = hit && (off == 2'd0);
    assign wr_cfg[g] = hit && (off == 2'd1);
  end

  always_comb begin
    rd_val = '0;
    if (icr_hit) begin
      for (int g = 0; g < NGRP; g++) begin
        if (grp_idx == GRP_W'(g)) begin
          case (kind_of(g, FIRST_MASK))
            GK_NMI: begin
              if (off == 2'd0) rd_val[0 +: NSRC] = req_flat[g*NSRC +: NSRC];
              else if (off == 2'd1) rd_val[0 +: NSRC] = en_flat[g*NSRC +: NSRC];
            end
            GK_MASK: begin
              if (off == 2'd0) begin
                rd_val[HI_LSB +: NSRC] = req_flat[g*NSRC +: NSRC];
                rd_val[0 +: NSRC]      = req_flat[g*NSRC +: NSRC] & en_flat[g*NSRC +: NSRC];
              end else if (off == 2'd1) begin
                rd_val[HI_LSB +: LVL_W] = lvl_flat[g*LVL_W +: LVL_W];
                rd_val[0 +: NSRC]       = en_flat[g*NSRC +: NSRC];
              end
            end
            default: rd_val = '0;
          endcase
        end
      end
    end else if (bus_addr == ADDR_W'(STAT_BASE)) begin
      rd_val = acc_pend ? DATA_W'({acc_grp, 2'b00}) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                bus_rdata <= '0;
    else if (bus_en && !bus_we) bus_rdata <= rd_val;
    else                       bus_rdata <= '0;
  end

endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import gic_pkg::*;
#(
  parameter int unsigned NGRP       = 31,
  parameter int unsigned NSRC       = 4,
  parameter int unsigned LVL_W      = 3,
  parameter int unsigned FIRST_MASK = 2,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned STAT_BASE  = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NGRP*NSRC-1:0] src_set,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 ack,
  input  logic [LVL_W-1:0]     ack_level,
  output logic [LVL_W-1:0]     irq_level,
  output logic                 nmi_pulse,
  output logic                 ack_err
);

  localparam int unsigned GRP_W = $clog2(NGRP);

  logic [NGRP*NSRC-1:0]  req_flat;
  logic [NGRP*NSRC-1:0]  en_flat;
  logic [NGRP*LVL_W-1:0] lvl_flat;
  logic [NGRP-1:0]       pend;
  logic [NGRP-1:0]       nmi_hit;
  logic [NGRP-1:0]       wr_ctl;
  logic [NGRP-1:0]       wr_cfg;
  logic [LVL_W-1:0]      best_lvl;
  logic [GRP_W-1:0]      best_grp;
  logic [GRP_W-1:0]      acc_grp;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam grp_kind_e K = kind_of(g, FIRST_MASK);
    if (K == GK_RSVD) begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = ^{src_set[g*NSRC +: NSRC], wr_ctl[g], wr_cfg[g]};
      assign req_flat[g*NSRC +: NSRC]   = '0;
      assign en_flat[g*NSRC +: NSRC]    = '0;
      assign lvl_flat[g*LVL_W +: LVL_W] = '1;
      assign pend[g]    = 1'b0;
      assign nmi_hit[g] = 1'b0;
    end else begin : g_live
      gic_group #(
        .NSRC  (NSRC),
        .LVL_W (LVL_W),
        .KIND  (K)
      ) u_group (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_set (src_set[g*NSRC +: NSRC]),
        .wr_ctl  (wr_ctl[g]),
        .wr_cfg  (wr_cfg[g]),
        .wdata   (bus_wdata),
        .req     (req_flat[g*NSRC +: NSRC]),
        .en      (en_flat[g*NSRC +: NSRC]),
        .lvl     (lvl_flat[g*LVL_W +: LVL_W]),
        .pend    (pend[g]),
        .nmi_hit (nmi_hit[g])
      );
    end
  end

  gic_prio_scan #(
    .NGRP       (NGRP),
    .FIRST_MASK (FIRST_MASK),
    .LVL_W      (LVL_W)
  ) u_scan (
    .pend     (pend),
    .lvl_flat (lvl_flat),
    .best_lvl (best_lvl),
    .best_grp (best_grp)
  );

  gic_regbus #(
    .NGRP       (NGRP),
    .NSRC       (NSRC),
    .LVL_W      (LVL_W),
    .FIRST_MASK (FIRST_MASK),
    .ADDR_W     (ADDR_W),
    .STAT_BASE  (STAT_BASE)
  ) u_regbus (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .req_flat  (req_flat),
    .en_flat   (en_flat),
    .lvl_flat  (lvl_flat),
    .acc_grp   (acc_grp),
    .acc_pend  (pend[acc_grp]),
    .wr_ctl    (wr_ctl),
    .wr_cfg    (wr_cfg),
    .bus_rdata (bus_rdata)
  );

  assign irq_level = best_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_grp   <= '0;
      ack_err   <= 1'b0;
      nmi_pulse <= 1'b0;
    end else begin
      if (ack) acc_grp <= best_grp;
      if (ack && (ack_level != best_lvl)) ack_err <= 1'b1;
      nmi_pulse <= |nmi_hit;
    end
  end

  // R3: nothing maskable pending means the idle level
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pend[NGRP-1:FIRST_MASK]) |-> (irq_level == '1));
  // R4: a non-idle level always names a pending group
  a_r4_sel_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '1) |-> pend[best_grp]);
  // R8: the pulse only accompanies a pending non-maskable group
  a_r8_nmi_pending: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pulse |-> pend[0]);
  // R10: the error flag never falls outside reset
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |=> ack_err);

endmodule

// File: tb/grp_irq_ctrl_tb.sv
module grp_irq_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NG = 31;
  localparam int WD_CYCLES = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [123:0] src_set = '0;
  logic         bus_en = 1'b0;
  logic         bus_we = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [7:0]   bus_wdata = '0;
  logic [7:0]   bus_rdata;
  logic         ack = 1'b0;
  logic [2:0]   ack_level = '0;
  logic [2:0]   irq_level;
  logic         nmi_pulse;
  logic         ack_err;

  int n_checks = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grp_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_set(src_set),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack(ack), .ack_level(ack_level),
    .irq_level(irq_level), .nmi_pulse(nmi_pulse), .ack_err(ack_err)
  );

  // Behavioural reference model
  int m_req[NG];
  int m_en[NG];
  int m_lvl[NG];
  int m_acc, m_rd;
  bit m_err, m_nmi;
  int p_sel, p_lv, t_src, t_id, t_ir, t_wd, c_sel, c_lv;

  task automatic model_best(output int sel, output int lv);
    sel = 0; lv = 7;
    for (int g = 2; g < NG; g++)
      if (((m_req[g] & m_en[g]) != 0) && (m_lvl[g] < lv)) begin
        sel = g; lv = m_lvl[g];
      end
  endtask

  function automatic int mread(input int a);
    int g, o;
    if (a < 124) begin
      g = a / 4; o = a % 4;
      if (g == 1 || o > 1) return 0;
      if (g == 0) return (o == 0) ? m_req[0] : m_en[0];
      if (o == 0) return (m_req[g] << 4) | (m_req[g] & m_en[g]);
      return (m_lvl[g] << 4) | m_en[g];
    end
    if (a == 128) return ((m_req[m_acc] & m_en[m_acc]) != 0) ? m_acc * 4 : 0;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) begin m_req[g] = 0; m_en[g] = 0; m_lvl[g] = 0; end
      m_acc = 0; m_err = 0; m_nmi = 0; m_rd = 0;
    end else begin
      model_best(p_sel, p_lv);
      m_rd = (bus_en && !bus_we) ? mread(int'(bus_addr)) : 0;
      if (ack) begin
        if (int'(ack_level) != p_lv) m_err = 1;
        m_acc = p_sel;
      end
      t_wd = int'(bus_wdata);
      for (int g = 0; g < NG; g++) begin
        t_src = int'(src_set[g*4 +: 4]);
        if (g != 1) begin
          if (bus_en && bus_we && int'(bus_addr) == g*4) begin
            t_id = t_wd & 15; t_ir = (t_wd >> 4) & 15;
            if (g == 0) m_req[0] = m_req[0] & ~t_id & 15;
            else m_req[g] = (m_req[g] & ~t_id & 15) | (t_ir & t_id);
          end
          if (bus_en && bus_we && int'(bus_addr) == g*4 + 1) begin
            m_en[g]  = t_wd & 15;
            m_lvl[g] = (g == 0) ? 0 : ((t_wd >> 4) & 7);
          end
          m_req[g] = m_req[g] | t_src;
        end
      end
      m_nmi = (src_set[3:0] != 4'd0) && ((m_req[0] & m_en[0]) != 0);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      model_best(c_sel, c_lv);
      check("R4 level vs model", int'(irq_level), c_lv);
      check("R8 nmi vs model", int'(nmi_pulse), int'(m_nmi));
      check("R10 err vs model", int'(ack_err), int'(m_err));
      check("R11 rdata vs model", int'(bus_rdata), m_rd);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = 8'(a);
    @(negedge clk);
    bus_en = 1'b0;
    v = int'(bus_rdata);
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    src_set[idx] = 1'b1;
    @(negedge clk);
    src_set[idx] = 1'b0;
  endtask

  task automatic wr_pulse(input int a, input int d, input int idx);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'(a); bus_wdata = 8'(d);
    src_set[idx] = 1'b1;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; src_set[idx] = 1'b0;
  endtask

  task automatic do_ack(input int lv);
    @(negedge clk);
    ack = 1'b1; ack_level = 3'(lv);
    @(negedge clk);
    ack = 1'b0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    check("R1 reset level", int'(irq_level), 7);
    check("R1 reset nmi", int'(nmi_pulse), 0);
    check("R1 reset err", int'(ack_err), 0);
    rst_n = 1'b1;
    rd(8'h15, v); check("R1 cfg byte after reset", v, 0);
    rd(8'h80, v); check("R1 accepted group after reset", v, 0);

    // Level-7 group is pending yet never wins
    wr(8'h1D, 8'h7F);
    pulse(28);
    check("R4 level-7 group hidden", int'(irq_level), 7);
    rd(8'h1C, v); check("R5 byte0 layout g7", v, 8'h11);

    wr(8'h15, 8'h3F);
    pulse(21);
    check("R3 pending group level", int'(irq_level), 3);
    rd(8'h14, v); check("R5 byte0 g5", v, 8'h22);
    rd(8'h15, v); check("R5 byte1 g5", v, 8'h3F);
    wr(8'h15, 8'h3D);
    check("R3 masked request not pending", int'(irq_level), 7);
    rd(8'h14, v); check("R3 masked ID field", v, 8'h20);
    wr(8'h15, 8'h3F);

    // Tie on level 3: group 5 beats group 10
    wr(8'h29, 8'h3F);
    pulse(40);
    check("R4 tie level", int'(irq_level), 3);
    do_ack(3);
    rd(8'h80, v); check("R4 tie picks lowest group", v, 8'h14);

    wr(8'h31, 8'h1F);
    pulse(50);
    check("R4 better level wins", int'(irq_level), 1);
    do_ack(1);
    rd(8'h80, v); check("R9 accepted group g12", v, 8'h30);
    rd(8'h81, v); check("R9 status byte1", v, 0);

    wr(8'h30, 8'h04);
    check("R6 clear drops level", int'(irq_level), 3);
    rd(8'h80, v); check("R9 lost request reads 0", v, 0);

    wr(8'h14, 8'hF0);
    rd(8'h14, v); check("R6 ID=0 leaves request", v, 8'h22);
    wr(8'h14, 8'h88);
    rd(8'h14, v); check("R6 set bit3", v, 8'hAA);

    wr_pulse(8'h1C, 8'h01, 28);
    rd(8'h1C, v); check("R6 pulse beats clear", v, 8'h11);

    // Non-maskable group
    wr(8'h01, 8'h71);
    rd(8'h01, v); check("R7 nmi byte1 level ignored", v, 8'h01);
    pulse(1);
    check("R8 no pulse when not pending", int'(nmi_pulse), 0);
    pulse(0);
    check("R8 pulse after pending event", int'(nmi_pulse), 1);
    @(negedge clk);
    check("R8 pulse lasts one cycle", int'(nmi_pulse), 0);
    rd(8'h00, v); check("R7 nmi byte0", v, 8'h03);
    wr(8'h00, 8'h01);
    rd(8'h00, v); check("R7 write-1 clears", v, 8'h02);

    check("R10 no error on matching acks", int'(ack_err), 0);
    do_ack(5);
    check("R10 mismatch sets error", int'(ack_err), 1);
    repeat (3) @(negedge clk);
    check("R10 error sticky", int'(ack_err), 1);

    // Ignored accesses
    wr(8'h04, 8'h7F);
    rd(8'h04, v); check("R11 group1 byte0", v, 0);
    rd(8'h05, v); check("R11 group1 byte1", v, 0);
    wr(8'h16, 8'hFF);
    rd(8'h14, v); check("R11 offset2 write ignored b0", v, 8'hAA);
    rd(8'h15, v); check("R11 offset2 write ignored b1", v, 8'h3F);
    wr(8'h7C, 8'hFF);
    rd(8'h7C, v); check("R11 beyond last group", v, 0);
    wr(8'h80, 8'hFF);
    rd(8'h80, v); check("R11 status not writable", v, 8'h14);
    rd(8'h90, v); check("R11 unmapped read", v, 0);
    @(negedge clk);
    check("R11 rdata idle after read", int'(bus_rdata), 0);

    pulse(4);
    check("R2 group1 pulse ignored level", int'(irq_level), 3);
    rd(8'h04, v); check("R2 group1 stays empty", v, 0);

    wr(8'h15, 8'h2F);
    check("R12 level follows write", int'(irq_level), 2);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule